// File: doc/BRIEF.md
# SDRAM DQ Latency Aligner

This block sits between an SDRAM command sequencer and the 32-bit DQ pins. It lines up the data path with the command stream. The sequencer raises a read strobe for every read beat it issues. The aligner then captures the DQ input exactly CAS-latency cycles later and hands the word to the host with a one-cycle valid pulse. Byte lanes the host did not enable read back as zero. The aligner also drives the four byte-mask pins early enough for the device's two-cycle read mask delay, when the programmed latency leaves room for it.

For writes, the word, the output enable and the byte masks all go out combinationally in the cycle of the write beat, which matches the device's zero-cycle write mask delay. A write beat is suppressed while any read return is outstanding, so the controller never drives the bus while the device may be driving it.

A burst-stop or precharge interrupt is signalled alongside the read strobe. The read beat coinciding with it is dropped. Beats already in flight still return, which is CAS latency minus one beats after the stop for latencies 1, 2 and 3.

Top module: `sdram_dq_align`

## Requirements
- R1: A read beat sampled at clock edge k (`rd_issue`=1, `rd_stop`=0) captures `dq_in` at edge k+CL. `rd_valid` is high for exactly the cycle after that edge and `rd_data` holds the captured word.
- R2: In captured read data, byte lane i (bits 8i+7..8i) is forced to zero when bit i of `host_be` was 0 with that read beat.
- R3: For a read beat, `dqm` carries the inverted `host_be` so that it reaches the device two cycles before the data. With CL=3 this is the cycle after the read beat. With CL=2 it is the read beat's own cycle. With CL=1 no read mask is driven and `dqm` stays 0000.
- R4: In a write beat that is accepted, `dq_out`=`host_wdata`, `dq_oe`=1 and `dqm`=~`host_be`, all in the same cycle.
- R5: A write beat is suppressed (`dq_oe`=0, `dqm`=1111 unless a read mask is due in that cycle) while any read capture is pending or while `rd_issue` is high in the same cycle. `dq_oe` is never high in the cycle before a read capture edge.
- R6: A read beat with `rd_stop`=1 is discarded. After the stop edge, exactly the in-flight beats return: CL-1 of them after a continuous burst.
- R7: After reset, `rd_valid`=0, `rd_data`=0, `dq_oe`=0 and `dqm`=0000.
- R8: A `cas_lat` value of 0 behaves as CL=1, and values above the maximum behave as the maximum.
- R9: With no write beat and no read mask due, `dq_oe`=0 and `dqm`=0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cas_lat | input | 2 | Programmed CAS latency (1..3) |
| rd_issue | input | 1 | Read beat issued this cycle |
| rd_stop | input | 1 | Burst stop / precharge interrupt this cycle |
| wr_issue | input | 1 | Write beat issued this cycle |
| host_be | input | 4 | Host byte enables, bit i for lane i |
| host_wdata | input | 32 | Host write word |
| dq_in | input | 32 | DQ pins, input side |
| dq_out | output | 32 | DQ pins, output side |
| dq_oe | output | 1 | DQ output enable |
| dqm | output | 4 | Byte mask pins, 1 = masked |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |

## Verification
Single read beats are run at every latency. They separate an off-by-one capture edge from a correct one, and they show where the read mask lands relative to the command. Back-to-back beats with a varying lane-enable pattern check that each word keeps its own mask. A moving DQ pattern makes a word taken one edge early or late visibly wrong.

A burst ending in a stop beat shows whether the coincident beat is dropped while the in-flight ones still arrive. Writes placed directly after a read separate the lane mask of the read from the all-ones mask of a suppressed write. The first write that is accepted afterwards marks the end of the blocking window.

// File: rtl/sdram_align_pkg.sv
`timescale 1ns/1ps
package sdram_align_pkg;
    // Clamp a raw latency setting into the supported 1..max range.
    function automatic int clamp_cl(input int raw, input int max_cl);
        if (raw < 1) return 1;
        if (raw > max_cl) return max_cl;
        return raw;
    endfunction
endpackage

// File: rtl/sdram_rd_track.sv
`timescale 1ns/1ps
module sdram_rd_track #(
    parameter int DW     = 32,
    parameter int MAX_CL = 3,
    localparam int LANES = DW / 8,
    localparam int CLW   = $clog2(MAX_CL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLW-1:0]   cl,
    input  logic             rd_go,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             busy
);
    typedef struct packed {
        logic [MAX_CL-1:0]            tok;
        logic [MAX_CL-1:0][LANES-1:0] lane;
        logic [DW-1:0]                data;
        logic                         valid;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tok  = s_q.tok >> 1;
        s_d.lane = s_q.lane >> LANES;
        for (int i = 0; i < MAX_CL; i++) begin
            if (rd_go && (i == int'(cl) - 1)) begin
                s_d.tok[i]  = 1'b1;
                s_d.lane[i] = be;
            end
        end
        s_d.valid = s_q.tok[0];
        if (s_q.tok[0]) begin
            for (int j = 0; j < LANES; j++) begin
                s_d.data[8*j +: 8] = s_q.lane[0][j] ? dq_in[8*j +: 8] : 8'h00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data  = s_q.data;
    assign rd_valid = s_q.valid;
    assign busy     = |s_q.tok;
endmodule

// File: rtl/sdram_mask_gen.sv
`timescale 1ns/1ps
module sdram_mask_gen #(
    parameter int DW     = 32,
    parameter int MAX_CL = 3,
    localparam int LANES = DW / 8,
    localparam int CLW   = $clog2(MAX_CL + 1),
    localparam int MDEP  = (MAX_CL > 2) ? MAX_CL - 2 : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLW-1:0]   cl,
    input  logic             rd_go,
    input  logic             wr_ok,
    input  logic             wr_blk,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] dqm
);
    typedef struct packed {
        logic [MDEP-1:0]            mv;
        logic [MDEP-1:0][LANES-1:0] mm;
    } msk_t;

    msk_t s_d, s_q;

    // Read masks are staged so they reach the pins CL-2 cycles after the beat.
    always_comb begin
        s_d    = s_q;
        s_d.mv = s_q.mv >> 1;
        s_d.mm = s_q.mm >> LANES;
        for (int i = 0; i < MDEP; i++) begin
            if (rd_go && (int'(cl) >= 3) && (i == int'(cl) - 3)) begin
                s_d.mv[i] = 1'b1;
                s_d.mm[i] = ~be;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        if (wr_ok)                          dqm = ~be;
        else if (rd_go && int'(cl) == 2)    dqm = ~be;
        else if (s_q.mv[0])                 dqm = s_q.mm[0];
        else if (wr_blk)                    dqm = '1;
        else                                dqm = '0;
    end
endmodule

// File: rtl/sdram_wr_path.sv
`timescale 1ns/1ps
module sdram_wr_path #(
    parameter int DW     = 32,
    localparam int LANES = DW / 8
) (
    input  logic          wr_issue,
    input  logic          rd_issue,
    input  logic          busy,
    input  logic [DW-1:0] wdata,
    output logic          wr_ok,
    output logic          wr_blk,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    always_comb begin
        wr_ok  = wr_issue && !busy && !rd_issue;
        wr_blk = wr_issue && !wr_ok;
        dq_oe  = wr_ok;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_out[8*g +: 8] = wr_ok ? wdata[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/sdram_dq_align.sv
`timescale 1ns/1ps
module sdram_dq_align
    import sdram_align_pkg::*;
#(
    parameter int DW     = 32,
    parameter int MAX_CL = 3,
    localparam int LANES = DW / 8,
    localparam int CLW   = $clog2(MAX_CL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLW-1:0]   cas_lat,
    input  logic             rd_issue,
    input  logic             rd_stop,
    input  logic             wr_issue,
    input  logic [LANES-1:0] host_be,
    input  logic [DW-1:0]    host_wdata,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    output logic [LANES-1:0] dqm,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid
);
    logic [CLW-1:0] cl_eff;
    logic           rd_go;
    logic           busy;
    logic           wr_ok;
    logic           wr_blk;

    always_comb begin
        cl_eff = CLW'(clamp_cl(int'(cas_lat), MAX_CL));
        rd_go  = rd_issue && !rd_stop;
    end

    sdram_rd_track #(.DW(DW), .MAX_CL(MAX_CL)) u_trk (
        .clk(clk), .rst_n(rst_n), .cl(cl_eff), .rd_go(rd_go), .be(host_be),
        .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    sdram_wr_path #(.DW(DW)) u_wr (
        .wr_issue(wr_issue), .rd_issue(rd_issue), .busy(busy), .wdata(host_wdata),
        .wr_ok(wr_ok), .wr_blk(wr_blk), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    sdram_mask_gen #(.DW(DW), .MAX_CL(MAX_CL)) u_msk (
        .clk(clk), .rst_n(rst_n), .cl(cl_eff), .rd_go(rd_go), .wr_ok(wr_ok),
        .wr_blk(wr_blk), .be(host_be), .dqm(dqm)
    );
endmodule

// File: rtl/sdram_dq_align_chk.sv
`timescale 1ns/1ps
module sdram_dq_align_chk #(
    parameter int DW     = 32,
    parameter int MAX_CL = 3,
    localparam int LANES = DW / 8,
    localparam int CLW   = $clog2(MAX_CL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CLW-1:0]   cas_lat,
    input logic             rd_issue,
    input logic             rd_stop,
    input logic             wr_issue,
    input logic [LANES-1:0] host_be,
    input logic             dq_oe,
    input logic [LANES-1:0] dqm,
    input logic             rd_valid
);
    int cl_c;
    always_comb begin
        if (int'(cas_lat) < 1)           cl_c = 1;
        else if (int'(cas_lat) > MAX_CL) cl_c = MAX_CL;
        else                             cl_c = int'(cas_lat);
    end

    assert_oe_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> wr_issue);
    assert_oe_lane_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dqm == ~host_be));
    assert_no_drive_with_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> !dq_oe);
    assert_no_return_after_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |=> !rd_valid);
    assert_lat1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cl_c == 1 && $stable(cas_lat)) |-> $past(rd_issue && !rd_stop, 2));
    assert_lat3_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cl_c == 3 && $stable(cas_lat)) |-> $past(rd_issue && !rd_stop, 4));
    assert_mask_cl2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_c == 2 && rd_issue && !rd_stop) |-> (dqm == ~host_be));
    assert_stop_drop_cl1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_c == 1 && rd_issue && rd_stop && !$past(rd_issue)) |-> ##2 !rd_valid);
endmodule

bind sdram_dq_align sdram_dq_align_chk #(.DW(DW), .MAX_CL(MAX_CL)) u_chk (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_issue(rd_issue),
    .rd_stop(rd_stop), .wr_issue(wr_issue), .host_be(host_be), .dq_oe(dq_oe),
    .dqm(dqm), .rd_valid(rd_valid)
);

// File: tb/sdram_dq_align_tb.sv
`timescale 1ns/1ps
module sdram_dq_align_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cas_lat = 2'd1;
    logic        rd_issue = 1'b0, rd_stop = 1'b0, wr_issue = 1'b0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0, dq_in = '0;
    logic [31:0] dq_out, rd_data;
    logic        dq_oe, rd_valid;
    logic [3:0]  dqm;

    always #2.5 clk = ~clk;

    sdram_dq_align u_dut (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_issue(rd_issue),
        .rd_stop(rd_stop), .wr_issue(wr_issue), .host_be(host_be),
        .host_wdata(host_wdata), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .dqm(dqm), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct { int due; logic [31:0] data; } exp_t;
    exp_t q[$];
    int errs = 0, checks = 0, cyc = 0, cl_eff = 1;
    int stop_cyc = 1 << 30, post_stop = 0;
    bit done = 0;

    function automatic logic [31:0] pat(input int n);
        return {n[15:0] ^ 16'hA5C3, ~n[15:0]};
    endfunction
    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) dq_in = pat(cyc);

    // Monitor: compare read returns against the scoreboard queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                e = q.pop_front();
                chk(rd_valid === 1'b1, "R1 valid strobe", {31'd0, rd_valid}, 32'd1);
                chk(rd_data === e.data, "R1/R2 read word", rd_data, e.data);
            end else if (rd_valid) begin
                chk(1'b0, "R1/R6 unexpected valid", rd_data, 32'd0);
            end
            if (rd_valid && cyc >= stop_cyc + 2) post_stop++;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_issue = 0; rd_stop = 0; wr_issue = 0; host_be = '0; host_wdata = '0;
        end
    endtask

    task automatic rd(input logic [3:0] be, input bit stop);
        exp_t e;
        @(negedge clk);
        wr_issue = 0; rd_issue = 1; rd_stop = stop; host_be = be;
        if (stop) stop_cyc = cyc;
        else begin
            e.due = cyc + cl_eff + 1;
            e.data = pat(cyc + cl_eff) & bmask(be);
            q.push_back(e);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be, input bit exp_oe, input logic [3:0] exp_dqm);
        @(negedge clk);
        rd_issue = 0; rd_stop = 0; wr_issue = 1; host_wdata = d; host_be = be;
        #1;
        chk(dq_oe === exp_oe, "R4/R5 output enable", {31'd0, dq_oe}, {31'd0, exp_oe});
        chk(dqm === exp_dqm, "R4/R5 write mask", {28'd0, dqm}, {28'd0, exp_dqm});
        if (exp_oe) chk(dq_out === d, "R4 write word", dq_out, d);
    endtask

    task automatic set_cl(input logic [1:0] raw, input int eff);
        idle(8);
        cas_lat = raw; cl_eff = eff;
        idle(2);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            chk(1'b0, "watchdog", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1;
        @(negedge clk); #1;
        chk(rd_valid === 0 && dq_oe === 0, "R7 reset strobes", {30'd0, rd_valid, dq_oe}, 32'd0);
        chk(dqm === 4'h0 && rd_data === 32'h0, "R7 reset mask/data", rd_data, 32'd0);

        for (int c = 1; c <= 3; c++) begin
            set_cl(2'(c), c);
            // single beat with mask placement
            rd(4'b0101, 0); #1;
            chk(dqm === (c == 2 ? 4'b1010 : 4'b0000), "R3 mask in beat cycle", {28'd0, dqm}, 32'd0);
            idle(1); #1;
            chk(dqm === (c == 3 ? 4'b1010 : 4'b0000), "R3 mask one cycle later", {28'd0, dqm}, 32'd0);
            idle(6);
            // back-to-back burst, each beat its own lanes (R1, R2)
            rd(4'hF, 0); rd(4'b1000, 0); rd(4'b0110, 0); rd(4'b0001, 0);
            idle(8);
            // interrupted burst (R6)
            post_stop = 0;
            rd(4'hF, 0); rd(4'hF, 0); rd(4'hF, 0); rd(4'hF, 0); rd(4'hF, 1);
            idle(8);
            chk(post_stop == c - 1, "R6 beats after stop", 32'(post_stop), 32'(c - 1));
            stop_cyc = 1 << 30;
        end

        // writes (R4) and idle (R9)
        set_cl(2'd2, 2);
        wr(32'hDEADBEEF, 4'hF, 1, 4'h0);
        wr(32'h12345678, 4'b0110, 1, 4'b1001);
        wr(32'h0F0F00FF, 4'b0000, 1, 4'hF);
        idle(1); #1;
        chk(dq_oe === 0 && dqm === 4'h0, "R9 idle pins", {27'd0, dq_oe, dqm}, 32'd0);

        // contention after a read at CL=3 (R5)
        set_cl(2'd3, 3);
        rd(4'b0011, 0);
        wr(32'hAAAA5555, 4'hF, 0, 4'b1100);
        wr(32'hAAAA5555, 4'hF, 0, 4'hF);
        wr(32'hAAAA5555, 4'hF, 0, 4'hF);
        wr(32'h5555AAAA, 4'b1010, 1, 4'b0101);
        idle(6);

        // read and write in the same cycle at CL=1 (R5)
        set_cl(2'd1, 1);
        rd(4'hF, 0);
        wr_issue = 1; host_wdata = 32'h11112222; #1;
        chk(dq_oe === 0, "R5 same-cycle read blocks write", {31'd0, dq_oe}, 32'd0);
        chk(dqm === 4'hF, "R5 suppressed write mask", {28'd0, dqm}, 32'hF);
        idle(6);

        // latency setting 0 acts as 1 (R8)
        set_cl(2'd0, 1);
        rd(4'b1100, 0);
        idle(6);

        idle(4);
        chk(q.size() == 0, "R1 all reads returned", 32'(q.size()), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule